// File: doc/BRIEF.md
# Two-Channel Compare-Match Up-Timer

This block holds two independent 16-bit up-counters that software reaches over a simple halfword register bus. Every channel divides the system clock by a prescale factor it selects itself (8, 32, 128 or 512) and advances its counter once per prescaled tick. When a running counter equals its compare value on a tick, it returns to zero on that same tick and, if the channel's interrupt enable is set, a one-clock pulse appears on that channel's interrupt output.

A single start register carries one run bit per channel. Clearing a run bit freezes the counter at its current value and resets the channel's prescaler, so a restart always waits a full prescale period before the first increment. Counter and compare registers may be read or written at any moment. A counter write takes priority over a tick on the same clock and suppresses any match on that clock.

Top module: `mt_timer2`

## Requirements
- R1: Register halfword byte offsets: 0 start, 2/4/6 control, counter and compare of channel 0, 8/10/12 the same for channel 1. Counter and compare read back the last value written. Offset 14 reads 0 and ignores writes.
- R2: Start register bit n (n = 0, 1) runs channel n when 1 and stops it when 0. It reads back the run bits, with bits 15:2 reading 0.
- R3: Control reads as bit 7 = 1, bit 6 = interrupt enable, bits 1:0 = clock select, and all other bits 0. Only bits 6 and 1:0 are stored on a write.
- R4: A running counter advances once every 8 << (2 * clock select) clocks. With compare value N the match interrupt repeats every (N+1) * divisor clocks.
- R5: On the tick where the counter equals the compare value, the counter becomes 0 instead of incrementing.
- R6: With enable set, a match raises the channel's interrupt bit for exactly one clock, starting on the clock after the matching tick. With enable clear, no pulse is produced, yet the counter still wraps.
- R7: A stopped counter keeps its value. After a restart the first increment comes a full prescale period after the start write.
- R8: After reset, start reads 0, counters read 0, compares read 0xFFFF, controls read 0x0080 and both interrupt bits are 0.
- R9: A counter write while the channel runs loads the written value.
- R10: The channels are independent: activity on one channel never changes the other's counter or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 together with bus_sel |
| bus_addr | input | 4 | Byte offset of the halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 2 | Per-channel compare-match interrupt pulse |

## Verification
The period of the interrupt is measured in clocks for several pairs of clock select and compare value, including compare 0 and the slowest divisor. This separates a wrong divisor from an off-by-one in the wrap. Random register writes and readbacks check the control masking and the start-bit width. Directed runs with the enable clear, and with a stop/restart in mid-count, show the wrap without a pulse, the counter hold and the prescaler clear. During each single-channel run the idle channel's interrupt is watched to expose any cross-channel coupling.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int NUM_CH      = 2;
    localparam int DATA_W      = 16;
    localparam int CKS_W       = 2;
    localparam int REGS_PER_CH = 3;
    localparam int BASE_DIV    = 8;
    localparam int MAX_DIV     = BASE_DIV << (2 * ((1 << CKS_W) - 1));
    localparam int PRE_W       = $clog2(MAX_DIV);
    localparam int ADDR_W      = $clog2(2 * (1 + REGS_PER_CH * NUM_CH));
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int IE_BIT      = 6;
    localparam int ONE_BIT     = 7;

    typedef enum logic [1:0] {
        RK_CTRL = 2'd0,
        RK_CNT  = 2'd1,
        RK_CMP  = 2'd2,
        RK_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic             ie;
        logic [CKS_W-1:0] cks;
    } ctrl_t;

    typedef struct packed {
        logic            is_start;
        reg_kind_e       kind;
        logic [CH_W-1:0] ch;
    } dec_t;

    // last prescaler count before a tick for a given clock select
    function automatic logic [PRE_W-1:0] div_last(input logic [CKS_W-1:0] cks);
        int d;
        d = BASE_DIV << (2 * int'(cks));
        return PRE_W'(d - 1);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(input ctrl_t c);
        logic [DATA_W-1:0] r;
        r              = '0;
        r[ONE_BIT]     = 1'b1;
        r[IE_BIT]      = c.ie;
        r[CKS_W-1:0]   = c.cks;
        return r;
    endfunction

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        int   h;
        int   idx;
        h          = int'(a) >> 1;
        d.is_start = 1'b0;
        d.kind     = RK_NONE;
        d.ch       = '0;
        if (h == 0) begin
            d.is_start = 1'b1;
        end else if (h <= REGS_PER_CH * NUM_CH) begin
            idx    = h - 1;
            d.ch   = CH_W'(idx / REGS_PER_CH);
            d.kind = reg_kind_e'(2'(idx % REGS_PER_CH));
        end
        return d;
    endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
    import mt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;

    // >= keeps a shortened divisor from overrunning after a mid-count change
    assign tick = run && (pre_q >= div_last(cks));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_ctrl,
    input  logic              wr_cnt,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] cmp,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cnt  <= '0;
            cmp  <= '1;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr_ctrl) begin
                ctrl.ie  <= wdata[IE_BIT];
                ctrl.cks <= wdata[CKS_W-1:0];
            end
            if (wr_cmp) begin
                cmp <= wdata;
            end
            if (wr_cnt) begin
                cnt <= wdata;
            end else if (tick) begin
                if (cnt == cmp) begin
                    cnt <= '0;
                    irq <= ctrl.ie;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mt_addr_map.sv
module mt_addr_map
    import mt_pkg::*;
(
    input  logic                          bus_sel,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [NUM_CH-1:0]             run,
    input  ctrl_t [NUM_CH-1:0]            ctrl_v,
    input  logic [NUM_CH-1:0][DATA_W-1:0] cnt_v,
    input  logic [NUM_CH-1:0][DATA_W-1:0] cmp_v,
    output logic                          wr_start,
    output logic [NUM_CH-1:0]             wr_ctrl,
    output logic [NUM_CH-1:0]             wr_cnt,
    output logic [NUM_CH-1:0]             wr_cmp,
    output logic [DATA_W-1:0]             rdata
);
    dec_t dec;
    logic wr;

    assign dec      = decode(bus_addr);
    assign wr       = bus_sel && bus_we;
    assign wr_start = wr && dec.is_start;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
        logic hit;
        assign hit        = wr && !dec.is_start && (dec.ch == CH_W'(i));
        assign wr_ctrl[i] = hit && (dec.kind == RK_CTRL);
        assign wr_cnt[i]  = hit && (dec.kind == RK_CNT);
        assign wr_cmp[i]  = hit && (dec.kind == RK_CMP);
    end

    always_comb begin
        rdata = '0;
        if (dec.is_start) begin
            rdata = DATA_W'(run);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (dec.ch == CH_W'(i)) begin
                    case (dec.kind)
                        RK_CTRL: rdata = ctrl_image(ctrl_v[i]);
                        RK_CNT:  rdata = cnt_v[i];
                        RK_CMP:  rdata = cmp_v[i];
                        default: rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/mt_timer2.sv
module mt_timer2
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_CH-1:0]             run_q;
    logic                          wr_start;
    logic [NUM_CH-1:0]             wr_ctrl;
    logic [NUM_CH-1:0]             wr_cnt;
    logic [NUM_CH-1:0]             wr_cmp;
    logic [NUM_CH-1:0]             tick;
    ctrl_t [NUM_CH-1:0]            ctrl_v;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_v;
    logic [NUM_CH-1:0][DATA_W-1:0] cmp_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (wr_start) begin
            run_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    mt_addr_map u_map (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .run      (run_q),
        .ctrl_v   (ctrl_v),
        .cnt_v    (cnt_v),
        .cmp_v    (cmp_v),
        .wr_start (wr_start),
        .wr_ctrl  (wr_ctrl),
        .wr_cnt   (wr_cnt),
        .wr_cmp   (wr_cmp),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        mt_prescaler u_pre (
            .clk  (clk),
            .rst  (rst),
            .run  (run_q[i]),
            .cks  (ctrl_v[i].cks),
            .tick (tick[i])
        );

        mt_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick[i]),
            .wr_ctrl (wr_ctrl[i]),
            .wr_cnt  (wr_cnt[i]),
            .wr_cmp  (wr_cmp[i]),
            .wdata   (bus_wdata),
            .ctrl    (ctrl_v[i]),
            .cnt     (cnt_v[i]),
            .cmp     (cmp_v[i]),
            .irq     (irq_o[i])
        );
    end
endmodule

// File: rtl/mt_checker.sv
module mt_checker
    import mt_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [NUM_CH-1:0]             irq_o,
    input logic [NUM_CH-1:0]             run_q,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt_v,
    input logic [NUM_CH-1:0]             wr_cnt
);
    logic ctrl_addr;
    int   hw;
    assign hw        = int'(bus_addr) >> 1;
    assign ctrl_addr = (hw != 0) && (hw <= REGS_PER_CH * NUM_CH) && (((hw - 1) % REGS_PER_CH) == 0);

    AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        ctrl_addr |-> bus_rdata[ONE_BIT]); // R3

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
        AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |=> !irq_o[i]); // R6

        AST_IRQ_RUNNING: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |-> $past(run_q[i])); // R6

        AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |-> (cnt_v[i] == '0)); // R5

        AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
            (!run_q[i] && !wr_cnt[i]) |=> (cnt_v[i] == $past(cnt_v[i]))); // R7
    end
endmodule

bind mt_timer2 mt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .run_q     (run_q),
    .cnt_v     (cnt_v),
    .wr_cnt    (wr_cnt)
);

// File: tb/mt_timer2_tb.sv
`timescale 1ns/1ps
module mt_timer2_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [1:0]  irq_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    mt_timer2 u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [3:0] a_ctrl(int ch); return 4'(2 + 6 * ch); endfunction
    function automatic logic [3:0] a_cnt(int ch);  return 4'(4 + 6 * ch); endfunction
    function automatic logic [3:0] a_cmp(int ch);  return 4'(6 + 6 * ch); endfunction
    function automatic int exp_div(int cks);       return 8 << (2 * cks); endfunction
    function automatic logic [15:0] exp_ctrl(logic [15:0] v); return 16'h0080 | (v & 16'h0043); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic period_test(int ch, int cks, int cmpv);
        int div;
        int n;
        int other;
        logic [15:0] v;
        div   = exp_div(cks);
        other = 0;
        bus_wr(4'd0, 16'h0);
        bus_wr(a_cnt(ch), 16'h0);
        bus_wr(a_cmp(ch), 16'(cmpv));
        bus_wr(a_ctrl(ch), 16'h0040 | 16'(cks));
        bus_wr(4'd0, 16'(1 << ch));
        n = 0;
        do begin
            @(posedge clk); #1; n++;
            if (irq_o[1 - ch]) other++;
        end while (!irq_o[ch] && n < 70000);
        chk("R4 first period", n, (cmpv + 1) * div);
        bus_rd(a_cnt(ch), v);
        chk("R5 counter zero after match", v, 0);
        @(posedge clk); #1;
        chk("R6 pulse one cycle", irq_o[ch], 0);
        n = 1;
        do begin
            @(posedge clk); #1; n++;
            if (irq_o[1 - ch]) other++;
        end while (!irq_o[ch] && n < 70000);
        chk("R4 second period", n, (cmpv + 1) * div);
        chk("R10 idle channel irq", other, 0);
        bus_wr(4'd0, 16'h0);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] v2;
        int n;
        int seen;
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R8 reset values
        bus_rd(4'd0, v);      chk("R8 start reset", v, 16'h0000);
        bus_rd(a_ctrl(0), v); chk("R8 ctrl0 reset", v, 16'h0080);
        bus_rd(a_ctrl(1), v); chk("R8 ctrl1 reset", v, 16'h0080);
        bus_rd(a_cnt(0), v);  chk("R8 cnt0 reset", v, 16'h0000);
        bus_rd(a_cnt(1), v);  chk("R8 cnt1 reset", v, 16'h0000);
        bus_rd(a_cmp(0), v);  chk("R8 cmp0 reset", v, 16'hFFFF);
        bus_rd(a_cmp(1), v);  chk("R8 cmp1 reset", v, 16'hFFFF);
        chk("R8 irq reset", irq_o, 2'b00);

        // R1 unmapped offset
        bus_wr(4'd14, 16'hBEEF);
        bus_rd(4'd14, v); chk("R1 unmapped reads zero", v, 0);
        bus_rd(a_cmp(1), v); chk("R1 unmapped write ignored", v, 16'hFFFF);

        // random register traffic
        for (int it = 0; it < 32; it++) begin
            int ch;
            int kind;
            logic [15:0] rv;
            ch   = int'($urandom % 2);
            kind = int'($urandom % 4);
            rv   = 16'($urandom);
            case (kind)
                0: begin
                    bus_wr(a_ctrl(ch), rv);
                    bus_rd(a_ctrl(ch), v); chk("R3 ctrl readback", v, exp_ctrl(rv));
                end
                1: begin
                    bus_wr(a_cmp(ch), rv);
                    bus_rd(a_cmp(ch), v); chk("R1 cmp readback", v, rv);
                end
                2: begin
                    bus_wr(a_cnt(ch), rv);
                    bus_rd(a_cnt(ch), v); chk("R1 cnt readback", v, rv);
                end
                default: begin
                    bus_wr(4'd0, rv);
                    bus_rd(4'd0, v); chk("R2 start readback", v, rv & 16'h0003);
                    bus_wr(4'd0, 16'h0);
                end
            endcase
        end

        // directed and random periods
        period_test(0, 0, 0);
        period_test(1, 3, 1);
        period_test(0, 2, 0);
        period_test(1, 0, 5);
        for (int it = 0; it < 4; it++) begin
            period_test(int'($urandom % 2), int'($urandom % 2), int'($urandom % 8));
        end

        // R6 enable clear: wrap without pulse
        bus_wr(a_cnt(1), 16'h0);
        bus_wr(a_cmp(1), 16'd2);
        bus_wr(a_ctrl(1), 16'h0000);
        bus_wr(4'd0, 16'h0002);
        seen = 0;
        for (int k = 0; k < 28; k++) begin
            @(posedge clk); #1;
            if (irq_o != 2'b00) seen++;
        end
        chk("R6 no pulse when disabled", seen, 0);
        bus_rd(a_cnt(1), v); chk("R5 wrap with enable clear", v, 0);
        bus_wr(4'd0, 16'h0);

        // R7 hold while stopped, prescaler clear on restart
        bus_wr(a_cnt(0), 16'h0);
        bus_wr(a_cmp(0), 16'hFFFF);
        bus_wr(a_ctrl(0), 16'h0000);
        bus_wr(4'd0, 16'h0001);
        bus_rd(4'd0, v); chk("R2 run bit set", v, 16'h0001);
        repeat (45) @(posedge clk);
        bus_wr(4'd0, 16'h0);
        bus_rd(a_cnt(0), v);
        repeat (100) @(posedge clk);
        bus_rd(a_cnt(0), v2); chk("R7 stopped counter holds", v2, v);
        bus_wr(4'd0, 16'h0001);
        bus_addr = a_cnt(0);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (bus_rdata == v && n < 1000);
        chk("R7 full period after restart", n, 8);
        chk("R7 single increment", bus_rdata, v + 16'd1);
        bus_wr(4'd0, 16'h0);

        // R9 counter load while running; R10 other counter untouched
        bus_wr(a_cnt(0), 16'h0777);
        bus_wr(a_cmp(1), 16'hFFFF);
        bus_wr(a_ctrl(1), 16'h0000);
        bus_wr(4'd0, 16'h0002);
        repeat (20) @(posedge clk);
        bus_wr(a_cnt(1), 16'h1234);
        bus_rd(a_cnt(1), v); chk("R9 load while running", v, 16'h1234);
        bus_rd(a_cnt(0), v); chk("R10 stopped channel counter", v, 16'h0777);
        bus_wr(4'd0, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule